// File: doc/BRIEF.md
# Five-Stage 8-bit Integer Pipeline

This block is a small in-order processing pipeline that works on 8-bit values. It accepts one 16-bit instruction per clock on a plain input port, so it has no fetch stage and no program counter. Its stages are decode, two execute stages, a memory stage and writeback, with a register at every stage boundary and at the block's inputs and outputs. The datapath holds an eight-entry register file of 8-bit values and an 8-bit adder. It also has an 8-by-8 carry-save array multiplier whose partial-product rows are split across the two execute stages, and a 32-byte data memory.

The four operations are add (with a small unsigned constant), multiply, load and store. A result that is written back appears on a registered writeback port. A store appears on a registered store port at the same edge at which it updates the data memory, so the surrounding logic can follow the architectural state. The pipeline does not detect hazards. A program must place an instruction that reads a register at least four issue slots after the instruction that writes it. The register file forwards a write to a read of the same register in the same cycle, so that distance of four slots is enough.

Top module: `pipe8_core`

## Requirements
- R1: After a synchronous active-high reset, every output is zero and every register and every data-memory byte reads as zero.
- R2: The instruction fields are [15:14] operation (00 add, 01 multiply, 10 load, 11 store), [13:11] destination, [10:8] first source, [7:5] second source and [4:0] an address or constant. Add writes first source + second source + the zero-extended [4:0] field, modulo 256.
- R3: Multiply writes the low 8 bits of the unsigned product of the two source registers.
- R4: Store writes the second source register into the data-memory byte at [4:0]. It drives st_vld, st_addr and st_data five cycles after the instruction is accepted, and it produces no writeback.
- R5: Load writes the data-memory byte at [4:0] into the destination register.
- R6: An accepted add, multiply or load raises wb_vld with wb_rd equal to its destination exactly six cycles after acceptance. A cycle with instr_vld low produces no output on either port.
- R7: An instruction issued exactly four slots after the writer of one of its sources receives the new value.
- R8: A load issued in the slot directly after a store to the same address returns the stored byte.
- R9: Independent instructions may be accepted on every cycle. Each one produces its own result in its own cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| instr_vld | input | 1 | An instruction is presented this cycle |
| instr | input | 16 | Instruction word |
| wb_vld | output | 1 | A register write was retired |
| wb_rd | output | 3 | Register written |
| wb_data | output | 8 | Value written |
| st_vld | output | 1 | A store updated the data memory |
| st_addr | output | 5 | Byte address stored to |
| st_data | output | 8 | Byte stored |

## Verification
The bench builds the pipeline with the default split of four multiplier rows in each execute stage. That split leaves a nonzero partial sum and carry vector in the middle register, so any error in carrying the intermediate state across the stage boundary shows up in the products. A mixed stream issued back to back, with dependent reads spaced at exactly the minimum distance of four slots, exercises the same-cycle register forwarding. Stores followed at once by loads of the same byte check the memory-stage ordering. Adds whose sums pass 255 check the wrap of the adder.

// File: rtl/pipe8_pkg.sv
package pipe8_pkg;

    localparam int XLEN      = 8;
    localparam int NREG      = 8;
    localparam int RIDX      = $clog2(NREG);
    localparam int MEM_BYTES = 32;
    localparam int AW        = $clog2(MEM_BYTES);
    localparam int PW        = 2 * XLEN;

    typedef enum logic [1:0] {
        OP_ADD = 2'b00,
        OP_MUL = 2'b01,
        OP_LD  = 2'b10,
        OP_ST  = 2'b11
    } op_e;

    typedef struct packed {
        op_e             op;
        logic [RIDX-1:0] rd;
        logic [RIDX-1:0] rs1;
        logic [RIDX-1:0] rs2;
        logic [AW-1:0]   fld;
    } instr_t;

    typedef struct packed {
        logic            vld;
        op_e             op;
        logic [RIDX-1:0] rd;
        logic [AW-1:0]   fld;
        logic [XLEN-1:0] a;
        logic [XLEN-1:0] b;
    } ex1_t;

    typedef struct packed {
        logic            vld;
        op_e             op;
        logic [RIDX-1:0] rd;
        logic [AW-1:0]   fld;
        logic [XLEN-1:0] alu;
        logic [PW-1:0]   ps;
        logic [PW-1:0]   pc;
        logic [XLEN-1:0] a;
        logic [XLEN-1:0] b;
    } ex2_t;

    typedef struct packed {
        logic            vld;
        op_e             op;
        logic [RIDX-1:0] rd;
        logic [AW-1:0]   fld;
        logic [XLEN-1:0] res;
    } mem_t;

    typedef struct packed {
        logic            vld;
        logic [RIDX-1:0] rd;
        logic [XLEN-1:0] data;
    } wb_t;

    typedef struct packed {
        logic [PW-1:0] s;
        logic [PW-1:0] c;
    } csa_t;

    // one 3:2 compression step over full product width
    function automatic csa_t csa3(logic [PW-1:0] x, logic [PW-1:0] y, logic [PW-1:0] z);
        csa_t r;
        r.s = x ^ y ^ z;
        r.c = ((x & y) | (x & z) | (y & z)) << 1;
        return r;
    endfunction

    // partial-product row i, aligned to its weight
    function automatic logic [PW-1:0] pprow(logic [XLEN-1:0] a, logic [XLEN-1:0] b, int i);
        logic [PW-1:0] ext;
        ext = {{(PW-XLEN){1'b0}}, a};
        return b[i] ? (ext << i) : '0;
    endfunction

endpackage

// File: rtl/pipe8_regfile.sv
module pipe8_regfile
    import pipe8_pkg::*;
#(
    parameter int N = NREG,
    parameter int W = XLEN,
    localparam int IW = $clog2(N)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [IW-1:0] ra1,
    input  logic [IW-1:0] ra2,
    output logic [W-1:0]  rd1,
    output logic [W-1:0]  rd2,
    input  logic          we,
    input  logic [IW-1:0] wa,
    input  logic [W-1:0]  wd
);
    logic [W-1:0] regs [N];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < N; i++) regs[i] <= '0;
        end else if (we) begin
            regs[wa] <= wd;
        end
    end

    // same-cycle write is seen by the read
    always_comb begin
        rd1 = (we && wa == ra1) ? wd : regs[ra1];
        rd2 = (we && wa == ra2) ? wd : regs[ra2];
    end
endmodule

// File: rtl/pipe8_dmem.sv
module pipe8_dmem
    import pipe8_pkg::*;
#(
    parameter int DEPTH = MEM_BYTES,
    parameter int W     = XLEN,
    localparam int A    = $clog2(DEPTH)
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         we,
    input  logic [A-1:0] addr,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] rdata
);
    logic [W-1:0] cells [DEPTH];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) cells[i] <= '0;
        end else if (we) begin
            cells[addr] <= wdata;
        end
    end

    assign rdata = cells[addr];
endmodule

// File: rtl/pipe8_csa_rows.sv
module pipe8_csa_rows
    import pipe8_pkg::*;
#(
    parameter int FIRST = 0,
    parameter int NROWS = 4
) (
    input  logic [XLEN-1:0] a,
    input  logic [XLEN-1:0] b,
    input  logic [PW-1:0]   s_in,
    input  logic [PW-1:0]   c_in,
    output logic [PW-1:0]   s_out,
    output logic [PW-1:0]   c_out
);
    for (genvar gi = 0; gi < NROWS; gi++) begin : g_row
        csa_t t;
        if (gi == 0) begin : g_head
            assign t = csa3(s_in, c_in, pprow(a, b, FIRST));
        end else begin : g_link
            assign t = csa3(g_row[gi-1].t.s, g_row[gi-1].t.c, pprow(a, b, FIRST + gi));
        end
    end

    assign s_out = g_row[NROWS-1].t.s;
    assign c_out = g_row[NROWS-1].t.c;
endmodule

// File: rtl/pipe8_core.sv
module pipe8_core
    import pipe8_pkg::*;
#(
    parameter int MUL_SPLIT = 4
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        instr_vld,
    input  logic [15:0] instr,
    output logic        wb_vld,
    output logic [2:0]  wb_rd,
    output logic [7:0]  wb_data,
    output logic        st_vld,
    output logic [4:0]  st_addr,
    output logic [7:0]  st_data
);
    localparam int TAIL_ROWS = XLEN - MUL_SPLIT;

    // input register
    logic   dec_vld;
    instr_t dec_ins;
    always_ff @(posedge clk) begin
        if (rst) begin
            dec_vld <= 1'b0;
            dec_ins <= '0;
        end else begin
            dec_vld <= instr_vld;
            dec_ins <= instr;
        end
    end

    // decode: register read
    wb_t             wb_q;
    logic [XLEN-1:0] rf_a, rf_b;

    pipe8_regfile u_rf (
        .clk (clk),
        .rst (rst),
        .ra1 (dec_ins.rs1),
        .ra2 (dec_ins.rs2),
        .rd1 (rf_a),
        .rd2 (rf_b),
        .we  (wb_q.vld),
        .wa  (wb_q.rd),
        .wd  (wb_q.data)
    );

    ex1_t ex1_q;
    always_ff @(posedge clk) begin
        if (rst) begin
            ex1_q <= '0;
        end else begin
            ex1_q.vld <= dec_vld;
            ex1_q.op  <= dec_ins.op;
            ex1_q.rd  <= dec_ins.rd;
            ex1_q.fld <= dec_ins.fld;
            ex1_q.a   <= rf_a;
            ex1_q.b   <= rf_b;
        end
    end

    // execute 1: adder and leading multiplier rows
    logic [XLEN-1:0] add_sum;
    logic [PW-1:0]   head_s, head_c;

    assign add_sum = ex1_q.a + ex1_q.b + XLEN'(ex1_q.fld);

    pipe8_csa_rows #(.FIRST(0), .NROWS(MUL_SPLIT)) u_mul_head (
        .a     (ex1_q.a),
        .b     (ex1_q.b),
        .s_in  ('0),
        .c_in  ('0),
        .s_out (head_s),
        .c_out (head_c)
    );

    ex2_t ex2_q;
    always_ff @(posedge clk) begin
        if (rst) begin
            ex2_q <= '0;
        end else begin
            ex2_q.vld <= ex1_q.vld;
            ex2_q.op  <= ex1_q.op;
            ex2_q.rd  <= ex1_q.rd;
            ex2_q.fld <= ex1_q.fld;
            ex2_q.alu <= (ex1_q.op == OP_ST) ? ex1_q.b : add_sum;
            ex2_q.ps  <= head_s;
            ex2_q.pc  <= head_c;
            ex2_q.a   <= ex1_q.a;
            ex2_q.b   <= ex1_q.b;
        end
    end

    // execute 2: trailing rows and final carry-propagate add
    logic [PW-1:0]   tail_s, tail_c, product;
    logic [XLEN-1:0] ex2_res;

    pipe8_csa_rows #(.FIRST(MUL_SPLIT), .NROWS(TAIL_ROWS)) u_mul_tail (
        .a     (ex2_q.a),
        .b     (ex2_q.b),
        .s_in  (ex2_q.ps),
        .c_in  (ex2_q.pc),
        .s_out (tail_s),
        .c_out (tail_c)
    );

    assign product = tail_s + tail_c;
    assign ex2_res = (ex2_q.op == OP_MUL) ? product[XLEN-1:0] : ex2_q.alu;

    mem_t mem_q;
    always_ff @(posedge clk) begin
        if (rst) begin
            mem_q <= '0;
        end else begin
            mem_q.vld <= ex2_q.vld;
            mem_q.op  <= ex2_q.op;
            mem_q.rd  <= ex2_q.rd;
            mem_q.fld <= ex2_q.fld;
            mem_q.res <= ex2_res;
        end
    end

    // memory stage
    logic            mem_we;
    logic [XLEN-1:0] mem_rdata;

    assign mem_we = mem_q.vld && (mem_q.op == OP_ST);

    pipe8_dmem u_dmem (
        .clk   (clk),
        .rst   (rst),
        .we    (mem_we),
        .addr  (mem_q.fld),
        .wdata (mem_q.res),
        .rdata (mem_rdata)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            wb_q    <= '0;
            st_vld  <= 1'b0;
            st_addr <= '0;
            st_data <= '0;
        end else begin
            wb_q.vld  <= mem_q.vld && (mem_q.op != OP_ST);
            wb_q.rd   <= mem_q.rd;
            wb_q.data <= (mem_q.op == OP_LD) ? mem_rdata : mem_q.res;
            st_vld    <= mem_we;
            st_addr   <= mem_q.fld;
            st_data   <= mem_q.res;
        end
    end

    // writeback: register file write and registered report
    always_ff @(posedge clk) begin
        if (rst) begin
            wb_vld  <= 1'b0;
            wb_rd   <= '0;
            wb_data <= '0;
        end else begin
            wb_vld  <= wb_q.vld;
            wb_rd   <= wb_q.rd;
            wb_data <= wb_q.data;
        end
    end
endmodule

// File: rtl/pipe8_core_chk.sv
module pipe8_core_chk (
    input logic        clk,
    input logic        rst,
    input logic        instr_vld,
    input logic [15:0] instr,
    input logic        wb_vld,
    input logic [2:0]  wb_rd,
    input logic        st_vld,
    input logic [4:0]  st_addr
);
    // cycles since reset, saturating
    logic [2:0] since;
    always_ff @(posedge clk) begin
        if (rst) since <= '0;
        else if (since != 3'd7) since <= since + 3'd1;
    end

    a_r1_quiet_after_reset: assert property (@(posedge clk)
        rst |=> (!wb_vld && !st_vld));

    a_r6_wb_latency: assert property (@(posedge clk) disable iff (rst)
        (since >= 3'd6) |-> (wb_vld == ($past(instr_vld, 6) && ($past(instr[15:14], 6) != 2'b11))));

    a_r6_wb_dest: assert property (@(posedge clk) disable iff (rst)
        (wb_vld && since >= 3'd6) |-> (wb_rd == $past(instr[13:11], 6)));

    a_r4_st_latency: assert property (@(posedge clk) disable iff (rst)
        (since >= 3'd5) |-> (st_vld == ($past(instr_vld, 5) && ($past(instr[15:14], 5) == 2'b11))));

    a_r4_st_addr: assert property (@(posedge clk) disable iff (rst)
        (st_vld && since >= 3'd5) |-> (st_addr == $past(instr[4:0], 5)));
endmodule

bind pipe8_core pipe8_core_chk u_chk (.*);

// File: tb/sim_pipe8_core.sv
module sim_pipe8_core;
    logic        clk = 1'b0;
    logic        rst;
    logic        instr_vld;
    logic [15:0] instr;
    logic        wb_vld;
    logic [2:0]  wb_rd;
    logic [7:0]  wb_data;
    logic        st_vld;
    logic [4:0]  st_addr;
    logic [7:0]  st_data;

    always #5 clk = ~clk;

    pipe8_core u0 (.*);

    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    // expected outputs, indexed by cycle modulo 8
    logic       ew_v [8];
    logic [2:0] ew_rd[8];
    logic [7:0] ew_d [8];
    string      ew_t [8];
    logic       es_v [8];
    logic [4:0] es_a [8];
    logic [7:0] es_d [8];
    string      es_t [8];

    // architectural reference state
    logic [7:0] rregs[8];
    logic [7:0] rmem [32];
    int         last_wr[8];

    int  checks = 0;
    int  fails  = 0;
    bit  chk_on = 0;
    bit  done   = 0;
    int unsigned seed = 32'h1234_5678;

    task automatic check(bit ok, string tag, string what, int act, int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0d expected=%0d at cycle %0d", tag, what, act, exp, cyc);
        end
    endtask

    always @(negedge clk) begin
        int s;
        if (chk_on) begin
            s = cyc % 8;
            check(wb_vld == ew_v[s], ew_v[s] ? ew_t[s] : "R6", "wb_vld", int'(wb_vld), int'(ew_v[s]));
            if (ew_v[s] && wb_vld) begin
                check(wb_rd == ew_rd[s], "R6", "wb_rd", int'(wb_rd), int'(ew_rd[s]));
                check(wb_data == ew_d[s], ew_t[s], "wb_data", int'(wb_data), int'(ew_d[s]));
            end
            check(st_vld == es_v[s], es_v[s] ? es_t[s] : "R6", "st_vld", int'(st_vld), int'(es_v[s]));
            if (es_v[s] && st_vld) begin
                check(st_addr == es_a[s], "R4", "st_addr", int'(st_addr), int'(es_a[s]));
                check(st_data == es_d[s], es_t[s], "st_data", int'(st_data), int'(es_d[s]));
            end
            ew_v[s] = 1'b0;
            es_v[s] = 1'b0;
        end
    end

    function automatic bit ready(logic [1:0] op, logic [2:0] rs1, logic [2:0] rs2);
        case (op)
            2'b00, 2'b01: return (cyc - last_wr[rs1] >= 4) && (cyc - last_wr[rs2] >= 4);
            2'b11:        return (cyc - last_wr[rs2] >= 4);
            default:      return 1'b1;
        endcase
    endfunction

    task automatic bubble();
        @(negedge clk);
        instr_vld = 1'b0;
        instr     = '0;
    endtask

    // waits, with bubbles, until sources are at least four slots old
    task automatic issue(logic [1:0] op, logic [2:0] rd, logic [2:0] rs1, logic [2:0] rs2,
                         logic [4:0] fld, string tag);
        int w, t;
        logic [7:0] v;
        @(negedge clk);
        while (!ready(op, rs1, rs2)) begin
            instr_vld = 1'b0;
            @(negedge clk);
        end
        instr_vld = 1'b1;
        instr     = {op, rd, rs1, rs2, fld};
        w = (cyc + 6) % 8;
        t = (cyc + 5) % 8;
        case (op)
            2'b00: v = rregs[rs1] + rregs[rs2] + {3'b000, fld};
            2'b01: v = 8'((16'(rregs[rs1]) * 16'(rregs[rs2])));
            2'b10: v = rmem[fld];
            default: v = '0;
        endcase
        if (op == 2'b11) begin
            rmem[fld] = rregs[rs2];
            es_v[t] = 1'b1; es_a[t] = fld; es_d[t] = rregs[rs2]; es_t[t] = tag;
        end else begin
            rregs[rd] = v;
            last_wr[rd] = cyc;
            ew_v[w] = 1'b1; ew_rd[w] = rd; ew_d[w] = v; ew_t[w] = tag;
        end
    endtask

    function automatic int unsigned rnd();
        seed ^= seed << 13;
        seed ^= seed >> 17;
        seed ^= seed << 5;
        return seed;
    endfunction

    initial begin
        for (int i = 0; i < 8; i++) begin
            ew_v[i] = 0; es_v[i] = 0; ew_rd[i] = 0; ew_d[i] = 0; es_a[i] = 0; es_d[i] = 0;
            rregs[i] = 0; last_wr[i] = -100;
        end
        for (int i = 0; i < 32; i++) rmem[i] = 0;
        rst = 1'b1; instr_vld = 1'b0; instr = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1: outputs are zero straight out of reset
        check(!wb_vld && wb_rd == 0 && wb_data == 0, "R1", "wb after reset", int'(wb_data), 0);
        check(!st_vld && st_addr == 0 && st_data == 0, "R1", "st after reset", int'(st_data), 0);
        chk_on = 1;

        // R1: every register and some memory bytes read back as zero
        for (int r = 0; r < 8; r++) issue(2'b11, 3'd0, 3'd0, 3'(r), 5'(r), "R1");
        issue(2'b10, 3'd1, 3'd0, 3'd0, 5'd31, "R1");
        issue(2'b10, 3'd2, 3'd0, 3'd0, 5'd16, "R1");

        // R2: add with constant, including wrap past 255
        issue(2'b00, 3'd1, 3'd0, 3'd0, 5'd5,  "R2");
        issue(2'b00, 3'd2, 3'd0, 3'd0, 5'd31, "R2");
        issue(2'b00, 3'd3, 3'd2, 3'd2, 5'd31, "R2");
        issue(2'b00, 3'd4, 3'd3, 3'd3, 5'd31, "R2");
        issue(2'b00, 3'd5, 3'd4, 3'd4, 5'd0,  "R2");

        // R3: products with high bits discarded
        issue(2'b01, 3'd6, 3'd4, 3'd3, 5'd0, "R3");
        issue(2'b01, 3'd7, 3'd6, 3'd6, 5'd0, "R3");
        issue(2'b01, 3'd0, 3'd4, 3'd4, 5'd0, "R3");

        // R7: reader at exactly four slots from its writer
        issue(2'b00, 3'd1, 3'd1, 3'd1, 5'd1, "R7");
        issue(2'b00, 3'd2, 3'd1, 3'd5, 5'd0, "R7");
        issue(2'b11, 3'd0, 3'd0, 3'd2, 5'd12, "R7");

        // R8: store followed at once by load of same byte
        issue(2'b11, 3'd0, 3'd0, 3'd5, 5'd9, "R8");
        issue(2'b10, 3'd3, 3'd0, 3'd0, 5'd9, "R8");
        issue(2'b11, 3'd0, 3'd0, 3'd7, 5'd9, "R8");
        issue(2'b10, 3'd4, 3'd0, 3'd0, 5'd9, "R8");

        // R5 and R9: loads and stores back to back
        issue(2'b10, 3'd1, 3'd0, 3'd0, 5'd12, "R5");
        issue(2'b11, 3'd0, 3'd0, 3'd6, 5'd20, "R9");
        issue(2'b10, 3'd5, 3'd0, 3'd0, 5'd9,  "R5");
        issue(2'b11, 3'd0, 3'd0, 3'd0, 5'd21, "R9");
        issue(2'b10, 3'd6, 3'd0, 3'd0, 5'd20, "R9");
        issue(2'b10, 3'd7, 3'd0, 3'd0, 5'd21, "R9");

        // R9: mixed stream, dependent reads held to the minimum spacing
        for (int n = 0; n < 600; n++) begin
            int unsigned x;
            string tg;
            x = rnd();
            case (x[1:0])
                2'b00: tg = "R2";
                2'b01: tg = "R3";
                2'b10: tg = "R5";
                default: tg = "R4";
            endcase
            if (x[31:29] == 3'd0) bubble();
            else issue(x[1:0], x[4:2], x[7:5], x[10:8], x[15:11], tg);
        end

        repeat (10) bubble();
        if (!done) begin
            done = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++;
            fails++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule